// File: doc/BRIEF.md
# Reflection Echo Interval Timer

This block measures how long a launched edge takes to come back from an unterminated line under test. On a start request it pulls its line drive output low. It then counts whole clock periods until the threshold comparator reports the returning echo. On the clock edge that first sees the echo, it also encodes a tapped delay chain snapshot, supplied as a thermometer-coded tap vector, into a sub-period fine code. The coarse and fine parts are merged into one timestamp, in units of one tap step.

The round trip equals twice the line length divided by the propagation speed. A line that is broken partway along therefore returns a shorter timestamp than an intact one. At the nominal 4 ns clock and roughly 100 ps per tap, one period spans 40 taps, and the timestamp is coarse × 40 + fine. A measurement that sees no echo within the count limit ends with a timeout pulse instead of a result. After a result or a timeout the line drive goes high again and the block accepts the next start.

Top module: `echo_timer`

## Requirements
- R1: While reset is held, and until a start is accepted, `line_drive` is 1, `stamp_valid` and `timeout` are 0 and `stamp` is 0.
- R2: A `start_req` sampled high while idle makes `line_drive` 0 after that clock edge (the launch edge); the line never falls without a start.
- R3: A `start_req` sampled while a measurement runs is ignored: the line stays low and the count keeps running from the original launch.
- R4: If `echo_in` is first sampled high C+1 edges after the launch edge (0 ≤ C ≤ 4095), then after that edge `stamp_valid` is 1, `stamp` = C × 40 + fine, and `line_drive` is 1.
- R5: The fine code is found as follows. Each tap i is replaced by the majority of taps i−1, i and i+1. The position below tap 0 counts as 1 and the position above tap 39 counts as 0. Tap 0 is the chain entry. The fine code is the index of the first 0 in the filtered vector, saturated at 39.
- R6: A single isolated flipped tap inside an otherwise clean thermometer code does not change the fine code.
- R7: If `echo_in` is still low at the edge 4096 edges after launch, then after that edge `timeout` is 1, `stamp_valid` is 0, `line_drive` is 1 and `stamp` keeps its old value.
- R8: `stamp_valid` and `timeout` are single-cycle pulses that are never high together, and `stamp` changes only with a `stamp_valid` pulse.
- R9: `echo_in` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one coarse unit per period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Request to launch a falling edge |
| echo_in | input | 1 | Threshold comparator output, high when the echo has returned |
| tap_vec | input | 40 | Delay chain snapshot, thermometer coded, bit 0 at chain entry |
| line_drive | output | 1 | Drive onto the line under test, idle high |
| stamp | output | 18 | Round-trip interval in tap units |
| stamp_valid | output | 1 | One-cycle pulse when `stamp` is updated |
| timeout | output | 1 | One-cycle pulse when no echo arrived in the window |

## Verification
A corrupted coarse count shows up as a timestamp that is off by a multiple of 40 in the very cycle the result is posted. A stuck run state shows up sooner, as `line_drive` staying low past the 4096-cycle window or rising without a result. A faulty fine encoder shows up as a timestamp whose remainder modulo 40 is wrong in that same cycle. This is most visible for bubbled and saturated tap vectors. Because the bench model tracks the line, the pulses and the timestamp on every clock, any divergence is reported in the first cycle it reaches a port.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/erst_sync.sv
module erst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/fine_encoder.sv
module fine_encoder #(
  parameter int TAPS   = 40,
  parameter int CODE_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]   taps,
  output logic [CODE_W-1:0] code
);
  logic [TAPS+1:0] ext;
  logic [TAPS-1:0] filt;

  // chain entry side counts as already passed, far end as not reached
  assign ext = {1'b0, taps, 1'b1};

  for (genvar i = 0; i < TAPS; i++) begin : g_vote
    assign filt[i] = (ext[i] & ext[i+1]) | (ext[i+1] & ext[i+2]) | (ext[i] & ext[i+2]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    code  = CODE_W'(TAPS - 1);
    for (int i = 0; i < TAPS; i++) begin
      if (!found && !filt[i]) begin
        code  = CODE_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coarse_counter.sv
module coarse_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr || en) cnt <= cnt_d;
  end
endmodule

// File: rtl/echo_timer.sv
module echo_timer #(
  parameter int TAPS  = 40,
  parameter int LIMIT = 4096,
  localparam int CODE_W  = $clog2(TAPS),
  localparam int CNT_W   = $clog2(LIMIT),
  localparam int STAMP_W = $clog2(LIMIT * TAPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               echo_in,
  input  logic [TAPS-1:0]    tap_vec,
  output logic               line_drive,
  output logic [STAMP_W-1:0] stamp,
  output logic               stamp_valid,
  output logic               timeout
);
  import echo_pkg::*;

  logic              srst_n;
  run_state_t        state_q, state_d;
  logic [CNT_W-1:0]  coarse;
  logic [CODE_W-1:0] fine;
  logic              launch, hit, expire, cnt_en;
  logic              line_d;
  logic [STAMP_W-1:0] stamp_d;

  erst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fine_encoder #(.TAPS(TAPS), .CODE_W(CODE_W)) u_fine (
    .taps (tap_vec),
    .code (fine)
  );

  coarse_counter #(.W(CNT_W)) u_coarse (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (launch),
    .en    (cnt_en),
    .cnt   (coarse)
  );

  // next-state logic
  always_comb begin
    launch  = (state_q == ST_IDLE) && start_req;
    hit     = (state_q == ST_RUN) && echo_in;
    expire  = (state_q == ST_RUN) && !echo_in && (coarse == CNT_W'(LIMIT - 1));
    cnt_en  = (state_q == ST_RUN) && !hit && !expire;
    state_d = state_q;
    line_d  = line_drive;
    if (launch) begin
      state_d = ST_RUN;
      line_d  = 1'b0;
    end else if (hit || expire) begin
      state_d = ST_IDLE;
      line_d  = 1'b1;
    end
    stamp_d = STAMP_W'(coarse) * STAMP_W'(TAPS) + STAMP_W'(fine);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q     <= ST_IDLE;
      line_drive  <= 1'b1;
      stamp_valid <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      state_q     <= state_d;
      line_drive  <= line_d;
      stamp_valid <= hit;
      timeout     <= expire;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)  stamp <= '0;
    else if (hit) stamp <= stamp_d;
  end
endmodule

// File: rtl/echo_timer_chk.sv
module echo_timer_chk #(
  parameter int LIMIT   = 4096,
  parameter int STAMP_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_req,
  input logic               line_drive,
  input logic [STAMP_W-1:0] stamp,
  input logic               stamp_valid,
  input logic               timeout
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (line_drive) low_cnt <= 0;
    else if (low_cnt < LIMIT + 2) low_cnt <= low_cnt + 1;
  end

  // R8
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stamp_valid && timeout));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid |=> !stamp_valid);

  // R8
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_valid |-> $stable(stamp));

  // R4
  release_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid |-> line_drive);

  // R2
  launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_drive) |-> $past(start_req));

  // R7
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LIMIT);

  // R7
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (line_drive && $past(!line_drive)));
endmodule

bind echo_timer echo_timer_chk #(.LIMIT(LIMIT), .STAMP_W(STAMP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_req   (start_req),
  .line_drive  (line_drive),
  .stamp       (stamp),
  .stamp_valid (stamp_valid),
  .timeout     (timeout)
);

// File: tb/sim_echo_timer.sv
`timescale 1ns/1ps
module sim_echo_timer;
  localparam int TAPS  = 40;
  localparam int LIMIT = 4096;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_req = 1'b0;
  logic            echo_in = 1'b0;
  logic [TAPS-1:0] tap_vec = '0;
  logic            line_drive, stamp_valid, timeout;
  logic [17:0]     stamp;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit cmp_en  = 1'b0;

  // reference model state
  bit m_busy, m_line, m_valid, m_tout;
  int m_cnt, m_stamp;

  always #2.5 clk = ~clk;

  echo_timer u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .echo_in(echo_in),
    .tap_vec(tap_vec), .line_drive(line_drive), .stamp(stamp),
    .stamp_valid(stamp_valid), .timeout(timeout)
  );

  function automatic logic [TAPS-1:0] therm(int k);
    logic [TAPS-1:0] v = '0;
    for (int i = 0; i < TAPS; i++) if (i < k) v[i] = 1'b1;
    return v;
  endfunction

  function automatic int ref_fine(logic [TAPS-1:0] t);
    for (int i = 0; i < TAPS; i++) begin
      int lo, hi, votes;
      lo = (i == 0) ? 1 : int'(t[i-1]);
      hi = (i == TAPS-1) ? 0 : int'(t[i+1]);
      votes = lo + int'(t[i]) + hi;
      if (votes < 2) return i;
    end
    return TAPS - 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_line = 1; m_valid = 0; m_tout = 0; m_cnt = 0; m_stamp = 0;
    end else begin
      m_valid = 0; m_tout = 0;
      if (!m_busy) begin
        if (start_req) begin m_busy = 1; m_cnt = 0; m_line = 0; end
      end else if (echo_in) begin
        m_stamp = m_cnt * TAPS + ref_fine(tap_vec);
        m_valid = 1; m_busy = 0; m_line = 1;
      end else if (m_cnt == LIMIT - 1) begin
        m_tout = 1; m_busy = 0; m_line = 1;
      end else m_cnt++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      chk(line_drive == m_line, "R2 line_drive vs model", int'(line_drive), int'(m_line));
      chk(stamp_valid == m_valid, "R4 stamp_valid vs model", int'(stamp_valid), int'(m_valid));
      chk(timeout == m_tout, "R7 timeout vs model", int'(timeout), int'(m_tout));
      chk(int'(stamp) == m_stamp, "R8 stamp vs model", int'(stamp), m_stamp);
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // launch, wait c edges, present echo with taps, step past the sampling edge
  task automatic measure(int c, logic [TAPS-1:0] t, int retrig_at);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    for (int i = 0; i < c; i++) begin
      if (i == retrig_at) start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    echo_in = 1'b1; tap_vec = t;
    @(negedge clk);
    echo_in = 1'b0;
  endtask

  initial begin
    logic [TAPS-1:0] bub;
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(line_drive == 1'b1, "R1 line idle high", int'(line_drive), 1);
    chk(stamp_valid == 1'b0, "R1 valid low", int'(stamp_valid), 0);
    chk(timeout == 1'b0, "R1 timeout low", int'(timeout), 0);
    chk(stamp == '0, "R1 stamp zero", int'(stamp), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R9 echo while idle
    echo_in = 1'b1; tap_vec = therm(20);
    repeat (5) @(negedge clk);
    chk(line_drive && !stamp_valid, "R9 echo ignored idle", int'(stamp_valid), 0);
    echo_in = 1'b0;

    // R4 basic measurement
    measure(5, therm(17), -1);
    chk(stamp_valid && int'(stamp) == 217, "R4 stamp C=5 fine=17", int'(stamp), 217);
    chk(line_drive == 1'b1, "R4 line released", int'(line_drive), 1);
    @(negedge clk);
    chk(!stamp_valid && int'(stamp) == 217, "R8 pulse ends and stamp holds", int'(stamp), 217);

    // R4 immediate echo, empty chain
    measure(0, '0, -1);
    chk(int'(stamp) == 0, "R4 stamp C=0 fine=0", int'(stamp), 0);

    // R5 saturation
    measure(2, '1, -1);
    chk(int'(stamp) == 119, "R5 saturated fine", int'(stamp), 119);
    measure(1, therm(39), -1);
    chk(int'(stamp) == 79, "R5 fine 39", int'(stamp), 79);

    // R6 bubbles
    bub = therm(10); bub[5] = 1'b0;
    measure(3, bub, -1);
    chk(int'(stamp) == 130, "R6 zero bubble", int'(stamp), 130);
    bub = therm(10); bub[20] = 1'b1;
    measure(3, bub, -1);
    chk(int'(stamp) == 130, "R6 one bubble", int'(stamp), 130);

    // R3 restart ignored while running
    measure(8, therm(4), 3);
    chk(int'(stamp) == 324, "R3 restart ignored", int'(stamp), 324);

    // R7 timeout
    held = int'(stamp);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (LIMIT - 1) @(negedge clk);
    chk(!line_drive && !timeout, "R7 still running at C=4094", int'(line_drive), 0);
    @(negedge clk);
    chk(timeout && !stamp_valid, "R7 timeout pulse", int'(timeout), 1);
    chk(line_drive == 1'b1, "R7 line released", int'(line_drive), 1);
    chk(int'(stamp) == held, "R7 stamp unchanged", int'(stamp), held);
    @(negedge clk);
    chk(!timeout, "R8 timeout single cycle", int'(timeout), 0);

    // R4 last in-window sample
    measure(LIMIT - 1, therm(7), -1);
    chk(stamp_valid && int'(stamp) == 163807, "R4 stamp at C=4095", int'(stamp), 163807);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule